// File: doc/BRIEF.md
# Line Reservation Monitor for Linked Load and Conditional Store

This block tracks per-line reservations so that a linked-load / conditional-store pair can be resolved at the moment a request finishes. Each completion arrives as a one-cycle strobe. The strobe carries four things: the line address, a two-bit operation code, the identifier of the requester, and a flag that says whether the line is currently resident in the cache.

For a linked load, the monitor records a reservation for that line and owner. For a conditional store, it decides the outcome from the table. An ordinary write completion can cancel a reservation held by its own requester. One clock after the strobe, the block returns a single-cycle result pulse together with a success bit.

The reservations live in a small table. Each entry holds a line address, an owner identifier and a valid flag. Each entry also carries an allocation age, so the oldest reservation can be displaced when the table is full. A bypass input turns the monitor into a pass-through: every operation succeeds and the table is left untouched.

Top module: `llsc_resv_mon`

## Requirements
- R1: A linked load (op code 2'b01) always reports success, and afterwards its line is reserved with the requester identifier as owner.
- R2: A conditional store (op code 2'b10) succeeds only when its line holds a reservation whose owner equals the requester identifier; in every other case it fails, including right after reset, when no line is reserved.
- R3: The result bit `res_ok_o` reads 1 for success and 0 for failure.
- R4: Every conditional store removes the reservation on its line, whatever its outcome and whoever owned it.
- R5: An ordinary write (op code 2'b00 or 2'b11) removes the reservation on its line only when `cmp_present_i` is 1 and the owner equals the requester. A write from another requester, or a write while the line is not present, leaves the reservation in place.
- R6: Every operation other than a conditional store reports success.
- R7: While `bypass_i` is 1, every completion reports success and no reservation is created, changed or removed.
- R8: The table holds `ENTRIES` (default 4) reservations.
  - A linked load to a line that is already reserved replaces the owner in the same entry, and this does not change the entry's age.
  - Otherwise the linked load takes the lowest-numbered free entry.
  - When no entry is free, it replaces the entry that was allocated longest ago.
- R9: `res_vld_o` is 0 after reset and pulses high exactly one clock after each cycle in which `cmp_vld_i` is 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | When 1, every operation succeeds and the table is frozen |
| cmp_vld_i | input | 1 | Completion strobe, one cycle per completed request |
| cmp_op_i | input | 2 | 00 write, 01 linked load, 10 conditional store, 11 locked write |
| cmp_line_i | input | LINE_W | Line address of the completed request |
| cmp_id_i | input | ID_W | Requester identifier |
| cmp_present_i | input | 1 | Line is resident in the cache |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| res_ok_o | output | 1 | Result: 1 success, 0 failure |

## Verification
A corrupted reservation table never shows up on its own. It surfaces only when a later conditional store to the affected line returns the wrong bit, one cycle after that store's strobe. The directed sequences therefore follow every state-changing step with a conditional store probe. Examples are a linked load followed by a foreign write, a reservation followed by a non-resident write, and a full table followed by one more allocation. This makes a lost, stale or misplaced entry appear as a miscompare within two completions. A wrong age ordering shows only after a fifth allocation, so the eviction test probes each of the surviving lines.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_LINKED = 2'b01,
    OP_COND   = 2'b10,
    OP_LOCKWR = 2'b11
  } llsc_op_e;

  // conditional store outcome: reservation present and owned by requester
  function automatic logic cond_grant(input logic hit, input logic owner_eq);
    return hit & owner_eq;
  endfunction

  // ordinary write cancels only its own reservation on a resident line
  function automatic logic write_cancels(input logic present, input logic hit,
                                         input logic owner_eq);
    return present & hit & owner_eq;
  endfunction

  // result bit reported for one completion
  function automatic logic result_bit(input logic bypass, input logic is_cond,
                                      input logic granted);
    return bypass | ~is_cond | granted;
  endfunction

endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0] line_tab_i,
  input  logic [ENTRIES-1:0][ID_W-1:0]   owner_tab_i,
  input  logic [LINE_W-1:0]              line_i,
  input  logic [ID_W-1:0]                id_i,
  output logic [ENTRIES-1:0]             hit_vec_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o,
  output logic                           owner_eq_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (line_tab_i[g] == line_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign owner_eq_o = hit_o && (owner_tab_i[hit_idx_o] == id_i);

  // R8: a line is never reserved in two entries at once
  unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec_o));

endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][IDX_W-1:0] rank_i,
  output logic                          has_free_o,
  output logic [IDX_W-1:0]              victim_o
);

  localparam logic [IDX_W-1:0] RANK_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   old_idx;
  logic [ENTRIES-1:0] is_oldest;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign is_oldest[g] = valid_i[g] && (rank_i[g] == RANK_MAX);
  end

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (is_oldest[i]) old_idx = IDX_W'(i);
    end
  end

  assign has_free_o = ~&valid_i;
  assign victim_o   = has_free_o ? free_idx : old_idx;

  // R8: a full table has exactly one oldest entry
  full_one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !has_free_o |-> ($countones(is_oldest) == 1));

endmodule

// File: rtl/llsc_table.sv
module llsc_table #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_en_i,
  input  logic [IDX_W-1:0]               alloc_idx_i,
  input  logic                           own_en_i,
  input  logic [IDX_W-1:0]               own_idx_i,
  input  logic                           clr_en_i,
  input  logic [IDX_W-1:0]               clr_idx_i,
  input  logic [LINE_W-1:0]              line_i,
  input  logic [ID_W-1:0]                id_i,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][LINE_W-1:0] line_o,
  output logic [ENTRIES-1:0][ID_W-1:0]   owner_o,
  output logic [ENTRIES-1:0][IDX_W-1:0]  rank_o
);

  // Ranks of valid entries stay a dense 0..V-1 set: 0 is the newest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= '0;
      line_o  <= '0;
      owner_o <= '0;
      rank_o  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_en_i) begin
          if (IDX_W'(i) == alloc_idx_i) begin
            valid_o[i] <= 1'b1;
            line_o[i]  <= line_i;
            owner_o[i] <= id_i;
            rank_o[i]  <= '0;
          end else if (valid_o[i]) begin
            rank_o[i] <= rank_o[i] + 1'b1;
          end
        end
        if (own_en_i && (IDX_W'(i) == own_idx_i)) begin
          owner_o[i] <= id_i;
        end
        if (clr_en_i) begin
          if (IDX_W'(i) == clr_idx_i) begin
            valid_o[i] <= 1'b0;
          end else if (valid_o[i] && (rank_o[i] > rank_o[clr_idx_i])) begin
            rank_o[i] <= rank_o[i] - 1'b1;
          end
        end
      end
    end
  end

  // R8: a fresh allocation is valid and newest on the next cycle
  alloc_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en_i |=> (valid_o[$past(alloc_idx_i)] && (rank_o[$past(alloc_idx_i)] == '0)));

  // R1: owner update on an existing reservation keeps it valid
  own_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_en_i |=> valid_o[$past(own_idx_i)]);

endmodule

// File: rtl/llsc_resv_mon.sv
module llsc_resv_mon #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_i,
  input  logic              cmp_vld_i,
  input  logic [1:0]        cmp_op_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic [ID_W-1:0]   cmp_id_i,
  input  logic              cmp_present_i,
  output logic              res_vld_o,
  output logic              res_ok_o
);
  import llsc_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [ENTRIES-1:0][ID_W-1:0]   owner_q;
  logic [ENTRIES-1:0][IDX_W-1:0]  rank_q;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic               owner_eq;
  logic               has_free;
  logic [IDX_W-1:0]   victim_idx;

  // named internal events
  logic active_ev, linked_ev, cond_ev, write_ev;
  logic link_new_ev, link_own_ev, clear_ev, ok_d;

  llsc_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) match_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_q),
    .line_tab_i (line_q),
    .owner_tab_i(owner_q),
    .line_i     (cmp_line_i),
    .id_i       (cmp_id_i),
    .hit_vec_o  (hit_vec),
    .hit_o      (hit_any),
    .hit_idx_o  (hit_idx),
    .owner_eq_o (owner_eq)
  );

  llsc_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_q),
    .rank_i    (rank_q),
    .has_free_o(has_free),
    .victim_o  (victim_idx)
  );

  assign active_ev   = cmp_vld_i & ~bypass_i;
  assign linked_ev   = active_ev & (cmp_op_i == OP_LINKED);
  assign cond_ev     = active_ev & (cmp_op_i == OP_COND);
  assign write_ev    = active_ev & ((cmp_op_i == OP_WRITE) | (cmp_op_i == OP_LOCKWR));
  assign link_new_ev = linked_ev & ~hit_any;
  assign link_own_ev = linked_ev & hit_any;
  assign clear_ev    = (cond_ev & hit_any) |
                       (write_ev & write_cancels(cmp_present_i, hit_any, owner_eq));
  assign ok_d        = result_bit(bypass_i, cmp_op_i == OP_COND,
                                  cond_grant(hit_any, owner_eq));

  llsc_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en_i (link_new_ev),
    .alloc_idx_i(victim_idx),
    .own_en_i   (link_own_ev),
    .own_idx_i  (hit_idx),
    .clr_en_i   (clear_ev),
    .clr_idx_i  (hit_idx),
    .line_i     (cmp_line_i),
    .id_i       (cmp_id_i),
    .valid_o    (valid_q),
    .line_o     (line_q),
    .owner_o    (owner_q),
    .rank_o     (rank_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o <= 1'b0;
      res_ok_o  <= 1'b0;
    end else begin
      res_vld_o <= cmp_vld_i;
      res_ok_o  <= cmp_vld_i & ok_d;
    end
  end

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i |=> res_vld_o);
  // R9
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_vld_i |=> !res_vld_o);
  // R7
  bypass_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && bypass_i) |=> res_ok_o);
  // R7
  bypass_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && bypass_i) |=> $stable(valid_q));
  // R1
  linked_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && (cmp_op_i == OP_LINKED)) |=> res_ok_o);
  // R6
  write_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && (cmp_op_i != OP_COND)) |=> res_ok_o);
  // R4
  cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ev && hit_any) |=> ((valid_q & $past(hit_vec)) == '0));
  // R2
  cond_miss_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ev && !hit_any) |=> !res_ok_o);

endmodule

// File: tb/llsc_resv_mon_tb_top.sv
`timescale 1ns/1ps
module llsc_resv_mon_tb_top;

  localparam int LW = 26;
  localparam int IW = 4;
  localparam logic [1:0] WR = 2'b00, LL = 2'b01, SC = 2'b10, LW_OP = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bypass_i = 1'b0;
  logic          cmp_vld_i = 1'b0;
  logic [1:0]    cmp_op_i = '0;
  logic [LW-1:0] cmp_line_i = '0;
  logic [IW-1:0] cmp_id_i = '0;
  logic          cmp_present_i = 1'b0;
  logic          res_vld_o, res_ok_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  llsc_resv_mon #(.ENTRIES(4), .LINE_W(LW), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i), .cmp_vld_i(cmp_vld_i),
    .cmp_op_i(cmp_op_i), .cmp_line_i(cmp_line_i), .cmp_id_i(cmp_id_i),
    .cmp_present_i(cmp_present_i), .res_vld_o(res_vld_o), .res_ok_o(res_ok_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one completion; result sampled one clock later at the falling edge
  task automatic xact(input logic [1:0] op, input logic [LW-1:0] ln,
                      input logic [IW-1:0] id, input logic pr, input logic byp,
                      input logic exp, input string tag);
    @(negedge clk);
    cmp_vld_i = 1'b1; cmp_op_i = op; cmp_line_i = ln;
    cmp_id_i = id; cmp_present_i = pr; bypass_i = byp;
    @(negedge clk);
    cmp_vld_i = 1'b0; bypass_i = 1'b0;
    check({tag, " R9 valid"}, res_vld_o, 1'b1);
    check(tag, res_ok_o, exp);
  endtask

  task automatic t_reset;
    check("R9 reset valid low", res_vld_o, 1'b0);
    xact(SC, 26'h100, 4'd0, 1'b1, 1'b0, 1'b0, "R2 no lock after reset");
    @(negedge clk);
    check("R9 single pulse", res_vld_o, 1'b0);
  endtask

  task automatic t_pair;
    xact(LL, 26'h200, 4'd1, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(SC, 26'h200, 4'd1, 1'b1, 1'b0, 1'b1, "R2 R3 owner store ok");
    xact(SC, 26'h200, 4'd1, 1'b1, 1'b0, 1'b0, "R4 cleared after success");
  endtask

  task automatic t_foreign_cond;
    xact(LL, 26'h300, 4'd2, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(SC, 26'h300, 4'd3, 1'b1, 1'b0, 1'b0, "R2 R3 other owner fails");
    xact(SC, 26'h300, 4'd2, 1'b1, 1'b0, 1'b0, "R4 cleared after failure");
  endtask

  task automatic t_writes;
    xact(LL, 26'h400, 4'd4, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(WR, 26'h400, 4'd4, 1'b1, 1'b0, 1'b1, "R6 write ok");
    xact(SC, 26'h400, 4'd4, 1'b1, 1'b0, 1'b0, "R5 own write cancels");
    xact(LL, 26'h410, 4'd4, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(LW_OP, 26'h410, 4'd4, 1'b1, 1'b0, 1'b1, "R6 locked write ok");
    xact(SC, 26'h410, 4'd4, 1'b1, 1'b0, 1'b0, "R5 locked write cancels");
    xact(LL, 26'h420, 4'd5, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(WR, 26'h420, 4'd6, 1'b1, 1'b0, 1'b1, "R6 foreign write ok");
    xact(WR, 26'h420, 4'd5, 1'b0, 1'b0, 1'b1, "R6 absent write ok");
    xact(SC, 26'h420, 4'd5, 1'b1, 1'b0, 1'b1, "R5 reservation kept");
  endtask

  task automatic t_overwrite;
    xact(LL, 26'h500, 4'd0, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(LL, 26'h500, 4'd7, 1'b1, 1'b0, 1'b1, "R8 relink ok");
    xact(SC, 26'h500, 4'd7, 1'b1, 1'b0, 1'b1, "R8 new owner wins");
    xact(LL, 26'h510, 4'd0, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(LL, 26'h510, 4'd7, 1'b1, 1'b0, 1'b1, "R8 relink ok");
    xact(SC, 26'h510, 4'd0, 1'b1, 1'b0, 1'b0, "R8 old owner loses");
  endtask

  task automatic t_evict;
    for (int k = 0; k < 4; k++)
      xact(LL, LW'(26'h600 + k), 4'd1, 1'b1, 1'b0, 1'b1, "R1 fill");
    xact(LL, 26'h604, 4'd1, 1'b1, 1'b0, 1'b1, "R8 fifth linked ok");
    xact(SC, 26'h600, 4'd1, 1'b1, 1'b0, 1'b0, "R8 oldest evicted");
    for (int k = 1; k < 5; k++)
      xact(SC, LW'(26'h600 + k), 4'd1, 1'b1, 1'b0, 1'b1, "R8 survivor kept");
    // free slot reuse must not evict
    for (int k = 0; k < 4; k++)
      xact(LL, LW'(26'h700 + k), 4'd2, 1'b1, 1'b0, 1'b1, "R1 fill");
    xact(SC, 26'h701, 4'd2, 1'b1, 1'b0, 1'b1, "R2 free one slot");
    xact(LL, 26'h705, 4'd2, 1'b1, 1'b0, 1'b1, "R8 into free slot");
    xact(LL, 26'h706, 4'd2, 1'b1, 1'b0, 1'b1, "R8 full again evicts 700");
    xact(SC, 26'h700, 4'd2, 1'b1, 1'b0, 1'b0, "R8 700 was oldest");
    xact(SC, 26'h702, 4'd2, 1'b1, 1'b0, 1'b1, "R8 702 kept");
    xact(SC, 26'h703, 4'd2, 1'b1, 1'b0, 1'b1, "R8 703 kept");
    xact(SC, 26'h705, 4'd2, 1'b1, 1'b0, 1'b1, "R8 705 kept");
    xact(SC, 26'h706, 4'd2, 1'b1, 1'b0, 1'b1, "R8 706 kept");
  endtask

  task automatic t_bypass;
    xact(SC, 26'h800, 4'd3, 1'b1, 1'b1, 1'b1, "R7 bypass unlocked ok");
    xact(LL, 26'h810, 4'd3, 1'b1, 1'b1, 1'b1, "R7 bypass linked ok");
    xact(SC, 26'h810, 4'd3, 1'b1, 1'b0, 1'b0, "R7 bypass made no lock");
    xact(LL, 26'h820, 4'd3, 1'b1, 1'b0, 1'b1, "R1 linked ok");
    xact(SC, 26'h820, 4'd9, 1'b1, 1'b1, 1'b1, "R7 bypass foreign ok");
    xact(WR, 26'h820, 4'd3, 1'b1, 1'b1, 1'b1, "R7 bypass write ok");
    xact(SC, 26'h820, 4'd3, 1'b1, 1'b0, 1'b1, "R7 lock untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_foreign_cond();
    t_writes();
    t_overwrite();
    t_evict();
    t_bypass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule